// File: doc/BRIEF.md
# Command List Register Writer

The block walks a list of 32-bit words delivered over a valid/ready stream and turns the list into writes to a local register array. Each write uses byte enables. A list is launched with a pulse on `start` together with its length in words.

Each command takes two words: a parameter value, then a header. The header names a target register, a 4-lane byte mask, a count of further parameter words, and a grouping flag. The flag decides whether those further words go to successive registers or all go to the same one. Commands always begin on an even word offset from the start of the list, so a single padding word is skipped whenever a command would otherwise begin at an odd offset.

The controller has four states:
- `ST_IDLE` waits for `start`. The transition `launch` moves it to `ST_PARAM`.
- `ST_PARAM` skips padding or captures the parameter word. The transition `got_param` moves it to `ST_HEADER`. The transition `list_done` returns it to `ST_IDLE`.
- `ST_HEADER` performs the first write. The transition `to_extra` moves it to `ST_EXTRA`. The transition `cmd_done` returns it to `ST_PARAM`. The transition `truncated` returns it to `ST_IDLE`.
- `ST_EXTRA` writes each further word. The transition `extra_done` returns it to `ST_PARAM`. The transition `truncated` returns it to `ST_IDLE`.

Each write that lands is reported for one cycle on the event outputs. A combinational read port exposes the register array.

Top module: `cmdlist_writer`

## Requirements
- R1: After reset, `busy`, `word_ready`, `evt_valid` and `trunc_err` are low, and every register reads zero.
- R2: `start` is taken only while `busy` is low. It latches `list_len`, clears `trunc_err`, resets the read position to 0, and raises `busy` on the next cycle. A `start` pulse while `busy` is high has no effect.
- R3: A command is a parameter word followed by a header word. The header fields are:
  - bits 15:0: register id
  - bits 19:16: lane mask
  - bits 27:20: extra-word count
  - bit 31: grouping flag
  - bits 30:28: ignored
  
  The first write puts the parameter value into the header's register id.
- R4: Mask bit k enables byte lane k, which is bits 8k+7:8k. For example, mask 0101 enables bits 7:0 and 23:16.
- R5: Every write stores (old AND NOT lanes) OR (value AND lanes). Bytes outside the mask keep their value.
- R6: With the grouping flag set, extra word i (counting from 1) goes to register id+i, using the header's mask.
- R7: With the grouping flag clear, every extra word goes to register id. Each one merges onto the result of the previous write.
- R8: When a command would begin at an odd word offset from the list start, one word is consumed and discarded first.
- R9: A write whose target id is at or above `NUM_REGS` changes no register and produces no event.
- R10: Once the read position equals the list length, `word_ready` drops and `busy` falls. If the list ends between commands, including right after a padding word, `trunc_err` stays low.
- R11: If the list ends after a parameter or header word but before the command's extra words are all read, `trunc_err` rises as `busy` falls. Writes already made remain. The flag holds until the next accepted `start`.
- R12: Each in-range write raises `evt_valid` for one cycle, one clock after the edge that accepted the word completing it. At the same time, `evt_id` carries the id and `evt_data` carries the merged value.
- R13: `word_ready` is high only while `busy` is high and the read position is below the list length. The word stream is otherwise never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a list (honoured when idle) |
| list_len | input | LEN_W | List length in words, sampled with start |
| word_valid | input | 1 | List word present |
| word_data | input | 32 | List word |
| word_ready | output | 1 | Block accepts the word this cycle |
| busy | output | 1 | A list is in progress |
| evt_valid | output | 1 | One-cycle write event |
| evt_id | output | 16 | Register id of the event |
| evt_data | output | 32 | Merged value written |
| trunc_err | output | 1 | List ended inside a command |
| rd_id | input | 16 | Read-port register id |
| rd_data | output | 32 | Register contents (zero if out of range) |

## Verification
In the same clock edge, the write of a command's last word and the end-of-list stop can coincide, as can a write that must merge onto the value written in the edge before. Lists are therefore generated whose length ends exactly on a command boundary, just after a padding word, or one or two words short. Runs of non-grouped extra words hit one register back to back. The bench judges each case by the event stream, by the final register contents read through the read port, and by `trunc_err` compared against a model that walks the same list.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;
    localparam int WORD_W = 32;
    localparam int ID_W   = 16;
    localparam int MASK_W = 4;
    localparam int CNT_W  = 8;
    localparam int ID_LSB   = 0;
    localparam int MASK_LSB = 16;
    localparam int CNT_LSB  = 20;
    localparam int GRP_BIT  = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PARAM,
        ST_HEADER,
        ST_EXTRA
    } cl_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   reg_id;
        logic [MASK_W-1:0] lanes;
        logic [CNT_W-1:0]  extra;
        logic              group;
    } cl_hdr_t;
endpackage

// File: rtl/cmdlist_hdr_dec.sv
module cmdlist_hdr_dec
    import cmdlist_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output cl_hdr_t           hdr
);
    always_comb begin
        hdr.reg_id = word[ID_LSB   +: ID_W];
        hdr.lanes  = word[MASK_LSB +: MASK_W];
        hdr.extra  = word[CNT_LSB  +: CNT_W];
        hdr.group  = word[GRP_BIT];
    end
endmodule

// File: rtl/cmdlist_regfile.sv
module cmdlist_regfile
    import cmdlist_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int TID_W    = ID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [TID_W-1:0]  wr_id,
    input  logic [MASK_W-1:0] wr_lanes,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] merged,
    output logic              in_range,
    input  logic [ID_W-1:0]   rd_id,
    output logic [WORD_W-1:0] rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [TID_W-1:0] LIMIT = TID_W'(NUM_REGS);

    logic [WORD_W-1:0] regs_q [NUM_REGS];
    logic [WORD_W-1:0] bytemask;
    logic [WORD_W-1:0] old_val;
    logic              rd_ok;

    // one lane of 8 bits per mask bit
    for (genvar b = 0; b < MASK_W; b++) begin : g_lane
        assign bytemask[8*b +: 8] = {8{wr_lanes[b]}};
    end

    assign in_range = (wr_id < LIMIT);
    assign old_val  = in_range ? regs_q[wr_id[IDX_W-1:0]] : '0;
    assign merged   = (old_val & ~bytemask) | (wr_data & bytemask);

    assign rd_ok   = ({1'b0, rd_id} < LIMIT);
    assign rd_data = rd_ok ? regs_q[rd_id[IDX_W-1:0]] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_en && in_range) begin
            regs_q[wr_id[IDX_W-1:0]] <= merged;
        end
    end
endmodule

// File: rtl/cmdlist_writer.sv
module cmdlist_writer
    import cmdlist_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  list_len,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              busy,
    output logic              evt_valid,
    output logic [ID_W-1:0]   evt_id,
    output logic [WORD_W-1:0] evt_data,
    output logic              trunc_err,
    input  logic [ID_W-1:0]   rd_id,
    output logic [WORD_W-1:0] rd_data
);
    localparam int TID_W = ID_W + 1;

    cl_state_e         state_q, state_d;
    logic [LEN_W-1:0]  pos_q, len_q;
    logic [WORD_W-1:0] param_q;
    logic [TID_W-1:0]  tgt_q;
    logic [MASK_W-1:0] lanes_q;
    logic [CNT_W-1:0]  left_q;
    logic              group_q;
    logic              err_q;

    logic              at_end, take, launch;
    cl_hdr_t           hdr;
    logic              wr_en, in_range;
    logic [TID_W-1:0]  wr_id;
    logic [MASK_W-1:0] wr_lanes;
    logic [WORD_W-1:0] wr_data, merged;

    cmdlist_hdr_dec u_dec (
        .word (word_data),
        .hdr  (hdr)
    );

    assign at_end     = (pos_q == len_q);
    assign busy       = (state_q != ST_IDLE);
    assign word_ready = busy && !at_end;
    assign take       = word_valid && word_ready;
    assign launch     = (state_q == ST_IDLE) && start;
    assign trunc_err  = err_q;

    // write port selection: header word writes the held parameter
    always_comb begin
        wr_en    = take && ((state_q == ST_HEADER) || (state_q == ST_EXTRA));
        wr_id    = (state_q == ST_HEADER) ? {1'b0, hdr.reg_id} : tgt_q;
        wr_lanes = (state_q == ST_HEADER) ? hdr.lanes : lanes_q;
        wr_data  = (state_q == ST_HEADER) ? param_q : word_data;
    end

    cmdlist_regfile #(
        .NUM_REGS (NUM_REGS),
        .TID_W    (TID_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_id    (wr_id),
        .wr_lanes (wr_lanes),
        .wr_data  (wr_data),
        .merged   (merged),
        .in_range (in_range),
        .rd_id    (rd_id),
        .rd_data  (rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PARAM;                       // launch
            ST_PARAM: begin
                if (at_end)                   state_d = ST_IDLE;            // list_done
                else if (take && !pos_q[0])   state_d = ST_HEADER;          // got_param
            end
            ST_HEADER: begin
                if (at_end)                   state_d = ST_IDLE;            // truncated
                else if (take)                state_d = (hdr.extra != '0) ? ST_EXTRA   // to_extra
                                                                           : ST_PARAM;  // cmd_done
            end
            ST_EXTRA: begin
                if (at_end)                   state_d = ST_IDLE;            // truncated
                else if (take && left_q == CNT_W'(1)) state_d = ST_PARAM;   // extra_done
            end
            default:                          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // list position, command context and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            len_q   <= '0;
            param_q <= '0;
            tgt_q   <= '0;
            lanes_q <= '0;
            left_q  <= '0;
            group_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (launch) begin
                len_q <= list_len;
                pos_q <= '0;
                err_q <= 1'b0;
            end else if (take) begin
                pos_q <= pos_q + LEN_W'(1);
            end
            if (((state_q == ST_HEADER) || (state_q == ST_EXTRA)) && at_end)
                err_q <= 1'b1;
            if (take && state_q == ST_PARAM && !pos_q[0])
                param_q <= word_data;
            if (take && state_q == ST_HEADER) begin
                lanes_q <= hdr.lanes;
                left_q  <= hdr.extra;
                group_q <= hdr.group;
                tgt_q   <= {1'b0, hdr.reg_id} + TID_W'(hdr.group);
            end
            if (take && state_q == ST_EXTRA) begin
                left_q <= left_q - CNT_W'(1);
                if (group_q) tgt_q <= tgt_q + TID_W'(1);
            end
        end
    end

    // registered write event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_id    <= '0;
            evt_data  <= '0;
        end else begin
            evt_valid <= wr_en && in_range;
            evt_id    <= wr_id[ID_W-1:0];
            evt_data  <= merged;
        end
    end
endmodule

// File: rtl/cmdlist_writer_chk.sv
module cmdlist_writer_chk #(
    parameter int NUM_REGS = 64
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        word_valid,
    input logic        word_ready,
    input logic        evt_valid,
    input logic [15:0] evt_id,
    input logic        trunc_err
);
    // R13
    ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> busy);
    // R9
    evt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (int'(evt_id) < NUM_REGS));
    // R12
    evt_from_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(word_valid && word_ready));
    // R11
    err_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trunc_err) |-> !busy);
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trunc_err && !start) |=> trunc_err);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
endmodule

bind cmdlist_writer cmdlist_writer_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .evt_valid  (evt_valid),
    .evt_id     (evt_id),
    .trunc_err  (trunc_err)
);

// File: tb/cmdlist_writer_test.sv
`timescale 1ns/1ps
module cmdlist_writer_test;
    localparam int NREG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] list_len = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready, busy, evt_valid, trunc_err;
    logic [15:0] evt_id;
    logic [31:0] evt_data, rd_data;
    logic [15:0] rd_id = '0;

    int tests = 0;
    int fails = 0;
    logic [31:0] mem [0:255];
    logic [31:0] model_r [NREG];
    int          exp_id [$];
    logic [31:0] exp_dat [$];
    logic        exp_err;

    cmdlist_writer #(.NUM_REGS(NREG), .LEN_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .list_len(list_len),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .busy(busy), .evt_valid(evt_valid), .evt_id(evt_id), .evt_data(evt_data),
        .trunc_err(trunc_err), .rd_id(rd_id), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] m);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{m[b]}};
        return r;
    endfunction

    function automatic logic [31:0] hdr(input int id, input logic [3:0] m, input int cnt, input logic g);
        return {g, 3'b000, 8'(cnt), m, 16'(id)};
    endfunction

    task automatic apply(input int id, input logic [31:0] v, input logic [3:0] m);
        logic [31:0] bm;
        if (id < NREG) begin
            bm = lanes(m);
            model_r[id] = (model_r[id] & ~bm) | (v & bm);
            exp_id.push_back(id);
            exp_dat.push_back(model_r[id]);
        end
    endtask

    task automatic model_list(input int len);
        int p, id, cnt;
        logic [3:0] m;
        logic g;
        logic [31:0] prm, h;
        p = 0;
        exp_err = 1'b0;
        while (p < len) begin
            if (p % 2 == 1) begin p++; continue; end
            prm = mem[p]; p++;
            if (p >= len) begin exp_err = 1'b1; break; end
            h = mem[p]; p++;
            id = int'(h[15:0]); m = h[19:16]; cnt = int'(h[27:20]); g = h[31];
            apply(id, prm, m);
            for (int i = 1; i <= cnt; i++) begin
                if (p >= len) begin exp_err = 1'b1; break; end
                apply(g ? id + i : id, mem[p], m);
                p++;
            end
            if (exp_err) break;
        end
    endtask

    // event monitor (R12)
    always @(negedge clk) begin
        if (rst_n && evt_valid) begin
            if (exp_id.size() == 0) begin
                tests++; fails++;
                $display("FAIL R12: actual event id %0d data %h expected no event", evt_id, evt_data);
            end else begin
                check("R12 event id", 32'(evt_id), 32'(exp_id.pop_front()));
                check("R5 event data", evt_data, exp_dat.pop_front());
            end
        end
    end

    task automatic run_list(input int len, input bit poke);
        int idx, cyc;
        bit acc;
        model_list(len);
        @(negedge clk);
        start = 1'b1; list_len = 16'(len);
        @(negedge clk);
        start = 1'b0; list_len = '0;
        idx = 0; cyc = 0;
        while (busy && idx < 256) begin
            word_valid = ($urandom % 4) != 0;
            word_data  = mem[idx];
            start = (poke && cyc == 3);
            #0.5;
            acc = word_valid && word_ready;
            @(negedge clk);
            if (acc) idx++;
            cyc++;
        end
        word_valid = 1'b0; start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R12 pending events", 32'(exp_id.size()), 32'd0);
        check("R11/R10 trunc_err", 32'(trunc_err), 32'(exp_err));
        check("R13 ready low when done", 32'(word_ready), 32'd0);
        for (int r = 0; r < NREG + 2; r++) begin
            rd_id = 16'(r);
            #0.1;
            check("R5 register contents", rd_data, (r < NREG) ? model_r[r] : 32'd0);
        end
    endtask

    task automatic reg_is(input string req, input int r, input logic [31:0] exp);
        rd_id = 16'(r);
        #0.1;
        check(req, rd_data, exp);
    endtask

    task automatic build_random(output int wcnt);
        int p, ncmd, cnt;
        p = 0;
        ncmd = 1 + int'($urandom % 6);
        for (int c = 0; c < ncmd; c++) begin
            if (p % 2 == 1) begin mem[p] = $urandom; p++; end
            cnt = int'($urandom % 4);
            mem[p] = $urandom;
            mem[p+1] = hdr(int'($urandom % 20), 4'($urandom), cnt, 1'($urandom));
            p += 2;
            for (int e = 0; e < cnt; e++) begin mem[p] = $urandom; p++; end
        end
        wcnt = p;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int w, len;
        void'($urandom(32'd1234));
        for (int r = 0; r < NREG; r++) model_r[r] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 ready", 32'(word_ready), 0);
        check("R1 evt_valid", 32'(evt_valid), 0);
        check("R1 trunc_err", 32'(trunc_err), 0);
        reg_is("R1 register zero", 3, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: full write then 0101 mask
        mem[0] = 32'hFFFF_FFFF; mem[1] = hdr(3, 4'hF, 0, 0);
        mem[2] = 32'h1122_3344; mem[3] = hdr(3, 4'b0101, 0, 0);
        run_list(4, 0);
        reg_is("R4 lane mask 0101", 3, 32'hFF22_FF44);

        // R6 grouped extras
        mem[0] = 32'hA0; mem[1] = hdr(5, 4'hF, 2, 1); mem[2] = 32'hA1; mem[3] = 32'hA2;
        run_list(4, 0);
        reg_is("R6 group base", 5, 32'hA0);
        reg_is("R6 group +1", 6, 32'hA1);
        reg_is("R6 group +2", 7, 32'hA2);

        // R7 same-id extras, half mask
        mem[0] = 32'h1111_1111; mem[1] = hdr(9, 4'b0011, 2, 0);
        mem[2] = 32'h2222_2222; mem[3] = 32'h3333_3333;
        run_list(4, 0);
        reg_is("R7 same id", 9, 32'h0000_3333);

        // R8 padding word skipped
        mem[0] = 32'h10; mem[1] = hdr(1, 4'hF, 1, 0); mem[2] = 32'h11;
        mem[3] = hdr(4, 4'hF, 0, 0); mem[4] = 32'h55; mem[5] = hdr(2, 4'hF, 0, 0);
        run_list(6, 0);
        reg_is("R8 after pad", 2, 32'h55);
        reg_is("R8 pad not a header", 4, 32'h0);

        // R9 out of range, group crossing the top
        mem[0] = 32'hBEEF; mem[1] = hdr(16, 4'hF, 0, 0);
        mem[2] = 32'hC0; mem[3] = hdr(14, 4'hF, 2, 1); mem[4] = 32'hC1; mem[5] = 32'hC2;
        run_list(6, 0);
        reg_is("R9 ignored id", 16, 32'h0);
        reg_is("R9 last in range", 15, 32'hC1);

        // R10 ends right after a pad word
        mem[0] = 32'h7; mem[1] = hdr(0, 4'hF, 1, 0); mem[2] = 32'h8; mem[3] = 32'h9;
        run_list(4, 0);
        check("R10 no error after pad", 32'(trunc_err), 0);

        // R11 truncation inside extras, then cleared by next start (R2)
        mem[0] = 32'hD0; mem[1] = hdr(11, 4'hF, 3, 1); mem[2] = 32'hD1;
        run_list(3, 0);
        check("R11 error raised", 32'(trunc_err), 1);
        mem[0] = 32'hE0; mem[1] = hdr(10, 4'hF, 0, 0);
        run_list(2, 1);
        check("R2 start clears error", 32'(trunc_err), 0);

        // random lists
        for (int k = 0; k < 40; k++) begin
            build_random(w);
            len = (($urandom % 4) == 0) ? w - 1 - int'($urandom % 2) : w;
            run_list(len, ($urandom % 3) == 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule